// File: doc/BRIEF.md
# Result Descriptor Ring Writeback Manager

This block keeps one ring of result descriptors in host memory up to date. The data store side raises an update trigger for every packet segment it has processed. For each accepted trigger the block issues a single DMA write command that places the result descriptor in the current ring slot. It then moves its write pointer forward by the slot stride and wraps the pointer back to the start of the ring at the ring size.

Alongside the writes, the block counts completed packets. In packet mode only a trigger that ends a packet is counted; in descriptor mode every written descriptor is counted. The threshold interrupt is held high while the count is above a programmed threshold. The host lowers the count and frees ring slots by writing an acknowledge word. A ring that already holds one slot less than its capacity refuses further writes: the refused write is dropped and a sticky overflow flag is set, and that flag can drive the overflow interrupt.

Software reaches everything through a small word-wide register port: base address, ring size, descriptor length and stride, threshold and counting mode, control, sticky status with write-one-to-clear, acknowledge, and a read-back of the pointer and counters. Writing zero to the control word stops external triggering while the ring is being set up.

Top module: `rdr_writeback`

## Requirements
- R1: After reset no DMA write is pending, both interrupts are low, and every register reads as zero, so triggering is off (control bit 0 is 0).
- R2: A trigger (`upd_valid`) that is accepted produces `dma_wr_valid` high in the following cycle, with `dma_wr_addr` equal to base plus the write pointer before the advance and `dma_wr_len` equal to the length field (bits 15:8 of register 2); status bit 2 is set.
- R3: Each accepted write advances the pointer by the stride (bits 7:0 of register 2); a sum at or above the ring size (register 1) makes the pointer 0 and sets status bit 5. Register 7 reads the packet count in bits 31:16 and the pointer in bits 15:0.
- R4: A trigger while control bit 0 is 0 produces no DMA write and leaves the pointer unchanged; status bit 6 is set.
- R5: With register 3 bit 31 at 1 (packet mode) the count rises only on an accepted trigger with `upd_last` high; with bit 31 at 0 every accepted write is counted (status bit 3 marks a counted write). The count saturates at its maximum.
- R6: `irq_thresh` is high exactly while the count is greater than the threshold (register 3 low bits); status bit 0 is set in every cycle in which it is high.
- R7: A trigger while occupancy plus stride is at or above the ring size is dropped (no DMA write, no pointer move, no count) and sets status bit 1; `irq_ovf` equals status bit 1 AND control bit 25.
- R8: A write to register 6 releases bits 23:16 descriptors (occupancy falls by that many strides) and bits 7:0 packets from the count; a release larger than what is held leaves zero and sets status bit 4. Every such write sets status bit 7. Register 6 reads the occupancy in bytes.
- R9: A trigger and an acknowledge in the same cycle both take effect: the write is issued and the count changes by the increment minus the release.
- R10: Writing ones to register 5 clears those status bits; an event in the same cycle keeps its bit set.
- R11: A write to register 1 clears the pointer, the occupancy and the count, and a trigger in the same cycle is discarded without a DMA write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| upd_valid | input | 1 | Update trigger, one per processed segment |
| upd_last | input | 1 | Trigger ends a packet |
| dma_wr_valid | output | 1 | One DMA write command this cycle |
| dma_wr_addr | output | ADDR_W | Host address of the ring slot |
| dma_wr_len | output | 8 | Descriptor length in bytes |
| irq_thresh | output | 1 | Processed count above threshold |
| irq_ovf | output | 1 | Overflow flag with its enable |

## Verification
The two functions that meet in one cycle are the counting of a new packet by an update trigger and its release by a host acknowledge; a second such pair is a status clear against a fresh status event. The bench drives both pairs deliberately on the same clock edge and then repeats them by chance through a long pseudo-random run. The judgement comes from a behavioural model that applies increment and release, and set and clear, in the order the requirements give; the count, the pointer, the status and the DMA outputs are compared with that model on every clock.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  typedef enum logic [2:0] {
    RG_BASE = 3'd0,
    RG_RING = 3'd1,
    RG_DESC = 3'd2,
    RG_THR  = 3'd3,
    RG_CTRL = 3'd4,
    RG_STAT = 3'd5,
    RG_ACK  = 3'd6,
    RG_INFO = 3'd7
  } rdr_reg_e;

  localparam int unsigned STAT_W = 8;
  localparam int unsigned FLD_W  = 8;

  localparam int unsigned ST_THR    = 0;
  localparam int unsigned ST_OVF    = 1;
  localparam int unsigned ST_WR     = 2;
  localparam int unsigned ST_PKT    = 3;
  localparam int unsigned ST_ACKERR = 4;
  localparam int unsigned ST_WRAP   = 5;
  localparam int unsigned ST_IGN    = 6;
  localparam int unsigned ST_ACK    = 7;

  localparam int unsigned CTRL_EN_BIT     = 0;
  localparam int unsigned CTRL_OVF_IE_BIT = 25;
  localparam int unsigned THR_MODE_BIT    = 31;

  typedef struct packed {
    logic [FLD_W-1:0] len;
    logic [FLD_W-1:0] stride;
  } desc_fmt_t;
endpackage

// File: rtl/rdr_cfg_regs.sv
module rdr_cfg_regs
  import rdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned RSZ_W  = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  input  logic [STAT_W-1:0] stat_set,
  input  logic [RSZ_W-1:0]  wptr,
  input  logic [RSZ_W-1:0]  occ,
  input  logic [CNT_W-1:0]  pkt_cnt,
  output logic [31:0]       rdata,
  output logic [ADDR_W-1:0] base,
  output logic [RSZ_W-1:0]  ring_bytes,
  output logic [FLD_W-1:0]  len,
  output logic [FLD_W-1:0]  stride,
  output logic [CNT_W-1:0]  thr,
  output logic              pkt_mode,
  output logic              trig_en,
  output logic              ovf_ie,
  output logic              ring_clr,
  output logic              ack_wr,
  output logic [FLD_W-1:0]  ack_pkts,
  output logic [FLD_W-1:0]  ack_descs,
  output logic [STAT_W-1:0] stat,
  output logic              irq_ovf
);
  logic [7:0]        hit;
  logic [ADDR_W-1:0] base_q;
  logic [RSZ_W-1:0]  ring_q;
  desc_fmt_t         desc_q;
  logic [CNT_W-1:0]  thr_q;
  logic              mode_q, en_q, ovfie_q;
  logic [STAT_W-1:0] stat_q, stat_d, stat_clr;

  always_comb begin
    hit = '0;
    if (we) hit[addr] = 1'b1;
  end

  assign stat_clr = hit[RG_STAT] ? wdata[STAT_W-1:0] : '0;

  always_comb begin
    stat_d = (stat_q & ~stat_clr) | stat_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      ring_q  <= '0;
      desc_q  <= '0;
      thr_q   <= '0;
      mode_q  <= 1'b0;
      en_q    <= 1'b0;
      ovfie_q <= 1'b0;
      stat_q  <= '0;
    end else begin
      if (hit[RG_BASE]) base_q <= wdata[ADDR_W-1:0];
      if (hit[RG_RING]) ring_q <= wdata[RSZ_W-1:0];
      if (hit[RG_DESC]) desc_q <= wdata[2*FLD_W-1:0];
      if (hit[RG_THR]) begin
        thr_q  <= wdata[CNT_W-1:0];
        mode_q <= wdata[THR_MODE_BIT];
      end
      if (hit[RG_CTRL]) begin
        en_q    <= wdata[CTRL_EN_BIT];
        ovfie_q <= wdata[CTRL_OVF_IE_BIT];
      end
      stat_q <= stat_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (rdr_reg_e'(addr))
      RG_BASE: rdata = 32'(base_q);
      RG_RING: rdata = 32'(ring_q);
      RG_DESC: rdata = 32'(desc_q);
      RG_THR: begin
        rdata = 32'(thr_q);
        rdata[THR_MODE_BIT] = mode_q;
      end
      RG_CTRL: begin
        rdata[CTRL_EN_BIT]     = en_q;
        rdata[CTRL_OVF_IE_BIT] = ovfie_q;
      end
      RG_STAT: rdata = 32'(stat_q);
      RG_ACK:  rdata = 32'(occ);
      RG_INFO: rdata = {16'(pkt_cnt), 16'(wptr)};
      default: rdata = '0;
    endcase
  end

  assign base       = base_q;
  assign ring_bytes = ring_q;
  assign len        = desc_q.len;
  assign stride     = desc_q.stride;
  assign thr        = thr_q;
  assign pkt_mode   = mode_q;
  assign trig_en    = en_q;
  assign ovf_ie     = ovfie_q;
  assign ring_clr   = hit[RG_RING];
  assign ack_wr     = hit[RG_ACK];
  assign ack_pkts   = wdata[FLD_W-1:0];
  assign ack_descs  = wdata[16 +: FLD_W];
  assign stat       = stat_q;
  assign irq_ovf    = stat_q[ST_OVF] & ovfie_q;
endmodule

// File: rtl/rdr_ring_track.sv
module rdr_ring_track
  import rdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned RSZ_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              ring_clr,
  input  logic [ADDR_W-1:0] base,
  input  logic [RSZ_W-1:0]  ring_bytes,
  input  logic [FLD_W-1:0]  stride,
  input  logic [FLD_W-1:0]  len,
  input  logic              ack_wr,
  input  logic [FLD_W-1:0]  ack_descs,
  output logic              accept,
  output logic              ovf_ev,
  output logic              wrap_ev,
  output logic              ack_err,
  output logic [RSZ_W-1:0]  wptr,
  output logic [RSZ_W-1:0]  occ,
  output logic              dma_valid,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [FLD_W-1:0]  dma_len
);
  localparam int unsigned OW = RSZ_W + 2*FLD_W + 1;

  logic [RSZ_W-1:0]  wptr_q, wptr_d, occ_q, occ_d;
  logic [OW-1:0]     ring_ext, step_ext, adv, held, rel;
  logic              full;
  logic              dv_q;
  logic [ADDR_W-1:0] da_q;
  logic [FLD_W-1:0]  dl_q;

  always_comb begin
    ring_ext = OW'(ring_bytes);
    step_ext = OW'(stride);
    full     = (OW'(occ_q) + step_ext) >= ring_ext;
    accept   = trig & ~ring_clr & ~full;
    ovf_ev   = trig & ~ring_clr & full;
    adv      = OW'(wptr_q) + step_ext;
    wrap_ev  = accept & (adv >= ring_ext);

    wptr_d = wptr_q;
    if (ring_clr)      wptr_d = '0;
    else if (accept)   wptr_d = wrap_ev ? '0 : RSZ_W'(adv);

    held    = OW'(occ_q) + (accept ? step_ext : '0);
    rel     = ack_wr ? (OW'(ack_descs) * step_ext) : '0;
    ack_err = ~ring_clr & (rel > held);
    if (ring_clr || ack_err) occ_d = '0;
    else                     occ_d = RSZ_W'(held - rel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      occ_q  <= '0;
      dv_q   <= 1'b0;
      da_q   <= '0;
      dl_q   <= '0;
    end else begin
      wptr_q <= wptr_d;
      occ_q  <= occ_d;
      dv_q   <= accept;
      if (accept) begin
        da_q <= base + ADDR_W'(wptr_q);
        dl_q <= len;
      end
    end
  end

  assign wptr      = wptr_q;
  assign occ       = occ_q;
  assign dma_valid = dv_q;
  assign dma_addr  = da_q;
  assign dma_len   = dl_q;
endmodule

// File: rtl/rdr_pkt_count.sv
module rdr_pkt_count
  import rdr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic             ack_wr,
  input  logic [FLD_W-1:0] ack_pkts,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic             ack_err
);
  localparam int unsigned CW = CNT_W + FLD_W + 1;
  localparam logic [CW-1:0] CMAX = CW'({CNT_W{1'b1}});

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CW-1:0]    bumped, rel;

  always_comb begin
    bumped = CW'(cnt_q) + CW'(inc);
    if (bumped > CMAX) bumped = CMAX;
    rel     = ack_wr ? CW'(ack_pkts) : '0;
    ack_err = ~clr & (rel > bumped);
    if (clr || ack_err) cnt_d = '0;
    else                cnt_d = CNT_W'(bumped - rel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
  assign irq = cnt_q > thr;
endmodule

// File: rtl/rdr_writeback.sv
module rdr_writeback
  import rdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned RSZ_W  = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              upd_valid,
  input  logic              upd_last,
  output logic              dma_wr_valid,
  output logic [ADDR_W-1:0] dma_wr_addr,
  output logic [FLD_W-1:0]  dma_wr_len,
  output logic              irq_thresh,
  output logic              irq_ovf
);
  logic [ADDR_W-1:0] base;
  logic [RSZ_W-1:0]  ring_bytes, wptr, occ;
  logic [FLD_W-1:0]  len, stride, ack_pkts, ack_descs;
  logic [CNT_W-1:0]  thr, pkt_cnt;
  logic              pkt_mode, trig_en, ovf_ie, ring_clr, ack_wr;
  logic [STAT_W-1:0] stat, stat_set;
  logic              trig, accept, ovf_ev, wrap_ev, ring_ack_err, cnt_ack_err, count_inc;

  assign trig      = upd_valid & trig_en;
  assign count_inc = accept & (pkt_mode ? upd_last : 1'b1);

  always_comb begin
    stat_set            = '0;
    stat_set[ST_THR]    = irq_thresh;
    stat_set[ST_OVF]    = ovf_ev;
    stat_set[ST_WR]     = accept;
    stat_set[ST_PKT]    = count_inc;
    stat_set[ST_ACKERR] = ring_ack_err | cnt_ack_err;
    stat_set[ST_WRAP]   = wrap_ev;
    stat_set[ST_IGN]    = upd_valid & ~trig_en;
    stat_set[ST_ACK]    = ack_wr;
  end

  rdr_cfg_regs #(.ADDR_W(ADDR_W), .RSZ_W(RSZ_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .stat_set(stat_set), .wptr(wptr), .occ(occ), .pkt_cnt(pkt_cnt),
    .rdata(cfg_rdata), .base(base), .ring_bytes(ring_bytes), .len(len),
    .stride(stride), .thr(thr), .pkt_mode(pkt_mode), .trig_en(trig_en),
    .ovf_ie(ovf_ie), .ring_clr(ring_clr), .ack_wr(ack_wr), .ack_pkts(ack_pkts),
    .ack_descs(ack_descs), .stat(stat), .irq_ovf(irq_ovf)
  );

  rdr_ring_track #(.ADDR_W(ADDR_W), .RSZ_W(RSZ_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .trig(trig), .ring_clr(ring_clr), .base(base),
    .ring_bytes(ring_bytes), .stride(stride), .len(len), .ack_wr(ack_wr),
    .ack_descs(ack_descs), .accept(accept), .ovf_ev(ovf_ev), .wrap_ev(wrap_ev),
    .ack_err(ring_ack_err), .wptr(wptr), .occ(occ), .dma_valid(dma_wr_valid),
    .dma_addr(dma_wr_addr), .dma_len(dma_wr_len)
  );

  rdr_pkt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(count_inc), .clr(ring_clr), .ack_wr(ack_wr),
    .ack_pkts(ack_pkts), .thr(thr), .cnt(pkt_cnt), .irq(irq_thresh),
    .ack_err(cnt_ack_err)
  );

  logic unused_view;
  assign unused_view = ^{stat, ovf_ie};
endmodule

// File: rtl/rdr_writeback_chk.sv
module rdr_writeback_chk
  import rdr_pkg::*;
#(
  parameter int unsigned RSZ_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [2:0]        cfg_addr,
  input logic [31:0]       cfg_wdata,
  input logic              upd_valid,
  input logic              trig_en,
  input logic              dma_wr_valid,
  input logic [RSZ_W-1:0]  ring_bytes,
  input logic [RSZ_W-1:0]  wptr,
  input logic [RSZ_W-1:0]  occ,
  input logic [CNT_W-1:0]  pkt_cnt,
  input logic              irq_thresh,
  input logic              ring_clr,
  input logic              ack_wr,
  input logic [STAT_W-1:0] stat
);
  logic              thr_wr;
  logic [STAT_W-1:0] clr_vec;
  assign thr_wr  = cfg_we && (cfg_addr == RG_THR);
  assign clr_vec = (cfg_we && (cfg_addr == RG_STAT)) ? cfg_wdata[STAT_W-1:0] : '0;

  assert_wptr_in_ring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_bytes != '0) |-> (wptr < ring_bytes));

  assert_ignored_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !trig_en) |=> !dma_wr_valid);

  assert_irq_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_thresh && !ring_clr && !ack_wr && !thr_wr) |=> irq_thresh);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) || (occ < ring_bytes));

  assert_sticky_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(stat & ~clr_vec)) == $past(stat & ~clr_vec)));

  assert_ring_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ring_clr |=> ((wptr == '0) && (occ == '0) && (pkt_cnt == '0) && !dma_wr_valid));
endmodule

bind rdr_writeback rdr_writeback_chk #(.RSZ_W(RSZ_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .upd_valid(upd_valid), .trig_en(trig_en),
  .dma_wr_valid(dma_wr_valid), .ring_bytes(ring_bytes), .wptr(wptr), .occ(occ),
  .pkt_cnt(pkt_cnt), .irq_thresh(irq_thresh), .ring_clr(ring_clr),
  .ack_wr(ack_wr), .stat(stat)
);

// File: tb/rdr_writeback_test.sv
`timescale 1ns/100ps
module rdr_writeback_test;
  logic        clk, rst_n, cfg_we, upd_valid, upd_last;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata, dma_wr_addr;
  logic [7:0]  dma_wr_len;
  logic        dma_wr_valid, irq_thresh, irq_ovf;
  int          tests = 0, fails = 0;
  bit          done = 0;

  rdr_writeback uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .upd_valid(upd_valid),
    .upd_last(upd_last), .dma_wr_valid(dma_wr_valid), .dma_wr_addr(dma_wr_addr),
    .dma_wr_len(dma_wr_len), .irq_thresh(irq_thresh), .irq_ovf(irq_ovf)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // behavioural reference state
  logic [31:0] m_base, m_daddr;
  int m_ring, m_len, m_stride, m_thr, m_wptr, m_occ, m_cnt, m_dlen;
  bit m_mode, m_en, m_ovfie, m_dv;
  logic [7:0] m_stat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base = 0; m_ring = 0; m_len = 0; m_stride = 0; m_thr = 0;
      m_mode = 0; m_en = 0; m_ovfie = 0; m_stat = 0;
      m_wptr = 0; m_occ = 0; m_cnt = 0; m_dv = 0; m_daddr = 0; m_dlen = 0;
    end else begin
      bit we, rclr, trig, full, acc, ovf, inc, wrap, aerr, ackw;
      int a, held, rel, bump, ackp, ackd;
      logic [7:0] set, clr;
      we = cfg_we; a = int'(cfg_addr);
      rclr = we && a == 1; ackw = we && a == 6;
      ackp = ackw ? int'(cfg_wdata[7:0]) : 0;
      ackd = ackw ? int'(cfg_wdata[23:16]) : 0;
      trig = upd_valid && m_en;
      full = (m_occ + m_stride) >= m_ring;
      acc = trig && !rclr && !full;
      ovf = trig && !rclr && full;
      inc = acc && (m_mode ? upd_last : 1'b1);
      wrap = 0; aerr = 0;
      set = 0;
      set[0] = m_cnt > m_thr;
      m_dv = acc;
      if (acc) begin m_daddr = m_base + 32'(m_wptr); m_dlen = m_len; end
      if (rclr) m_wptr = 0;
      else if (acc) begin
        if (m_wptr + m_stride >= m_ring) begin m_wptr = 0; wrap = 1; end
        else m_wptr = m_wptr + m_stride;
      end
      if (rclr) m_occ = 0;
      else begin
        held = m_occ + (acc ? m_stride : 0);
        rel = ackd * m_stride;
        if (rel > held) begin m_occ = 0; aerr = 1; end else m_occ = held - rel;
      end
      if (rclr) m_cnt = 0;
      else begin
        bump = m_cnt + (inc ? 1 : 0);
        if (bump > 65535) bump = 65535;
        if (ackp > bump) begin m_cnt = 0; aerr = 1; end else m_cnt = bump - ackp;
      end
      set[1] = ovf; set[2] = acc; set[3] = inc; set[4] = aerr; set[5] = wrap;
      set[6] = upd_valid && !m_en; set[7] = ackw;
      clr = (we && a == 5) ? cfg_wdata[7:0] : 8'h00;
      m_stat = (m_stat & ~clr) | set;
      if (we) case (a)
        0: m_base = cfg_wdata;
        1: m_ring = int'(cfg_wdata[15:0]);
        2: begin m_stride = int'(cfg_wdata[7:0]); m_len = int'(cfg_wdata[15:8]); end
        3: begin m_thr = int'(cfg_wdata[15:0]); m_mode = cfg_wdata[31]; end
        4: begin m_en = cfg_wdata[0]; m_ovfie = cfg_wdata[25]; end
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_base;
      3'd1: return 32'(m_ring);
      3'd2: return 32'((m_len << 8) | m_stride);
      3'd3: return {m_mode, 15'd0, 16'(m_thr)};
      3'd4: return {6'd0, m_ovfie, 24'd0, m_en};
      3'd5: return {24'd0, m_stat};
      3'd6: return 32'(m_occ);
      default: return {16'(m_cnt), 16'(m_wptr)};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 dma_wr_valid", 32'(dma_wr_valid), 32'(m_dv));
      if (m_dv) begin
        chk("R2 dma_wr_addr", dma_wr_addr, m_daddr);
        chk("R2 dma_wr_len", 32'(dma_wr_len), 32'(m_dlen));
      end
      chk("R6 irq_thresh", 32'(irq_thresh), 32'(m_cnt > m_thr));
      chk("R7 irq_ovf", 32'(irq_ovf), 32'(m_stat[1] & m_ovfie));
      chk("R3 cfg_rdata", cfg_rdata, m_read(cfg_addr));
    end
  end

  task automatic summary();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic step(); @(negedge clk); #1; endtask
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; step(); cfg_we = 0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    cfg_addr = a; step(); v = cfg_rdata;
  endtask
  task automatic fire(input bit last);
    upd_valid = 1; upd_last = last; step(); upd_valid = 0; upd_last = 0;
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; upd_valid = 0; upd_last = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    step();
    chk("R1 dma_wr_valid", 32'(dma_wr_valid), 0);
    chk("R1 irq_thresh", 32'(irq_thresh), 0);
    chk("R1 irq_ovf", 32'(irq_ovf), 0);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      chk("R1 register reset", v, 0);
    end

    wr(3'd0, 32'h1000_0000);
    wr(3'd1, 32'd64);
    wr(3'd2, 32'h0000_2010);
    wr(3'd3, 32'h8000_0001);
    wr(3'd4, 32'h0200_0001);

    fire(0);
    chk("R2 first write valid", 32'(dma_wr_valid), 1);
    chk("R2 first write addr", dma_wr_addr, 32'h1000_0000);
    chk("R2 first write len", 32'(dma_wr_len), 32'd32);
    fire(1);
    chk("R3 second slot addr", dma_wr_addr, 32'h1000_0010);
    chk("R5 one packet not above thr", 32'(irq_thresh), 0);
    fire(1);
    chk("R6 count above thr", 32'(irq_thresh), 1);
    fire(0);
    chk("R7 full ring drops write", 32'(dma_wr_valid), 0);
    chk("R7 overflow irq", 32'(irq_ovf), 1);
    wr(3'd6, 32'h0003_0001);
    chk("R8 ack lowers irq", 32'(irq_thresh), 0);
    rd(3'd6, v);
    chk("R8 occupancy freed", v, 0);
    fire(0);
    chk("R3 last slot addr", dma_wr_addr, 32'h1000_0030);
    rd(3'd7, v);
    chk("R3 pointer wrapped", v, 32'h0001_0000);
    wr(3'd5, 32'hFF);
    rd(3'd5, v);
    chk("R10 status cleared", v, 0);

    wr(3'd4, 32'h0200_0000);
    fire(1);
    chk("R4 disabled no write", 32'(dma_wr_valid), 0);
    rd(3'd5, v);
    chk("R4 ignored flag", v, 32'h40);
    rd(3'd7, v);
    chk("R4 pointer unchanged", v, 32'h0001_0000);

    wr(3'd4, 32'h0200_0001);
    cfg_we = 1; cfg_addr = 3'd5; cfg_wdata = 32'hFF; upd_valid = 1; upd_last = 0;
    step(); cfg_we = 0; upd_valid = 0;
    chk("R10 write during clear", dma_wr_addr, 32'h1000_0000);
    rd(3'd5, v);
    chk("R10 set wins over clear", v, 32'h04);

    cfg_we = 1; cfg_addr = 3'd6; cfg_wdata = 32'h1; upd_valid = 1; upd_last = 1;
    step(); cfg_we = 0; upd_valid = 0; upd_last = 0;
    chk("R9 write with ack", dma_wr_addr, 32'h1000_0010);
    rd(3'd7, v);
    chk("R9 count net of ack", v, 32'h0001_0020);

    cfg_we = 1; cfg_addr = 3'd1; cfg_wdata = 32'd128; upd_valid = 1;
    step(); cfg_we = 0; upd_valid = 0;
    chk("R11 trigger discarded", 32'(dma_wr_valid), 0);
    rd(3'd7, v);
    chk("R11 pointer and count cleared", v, 0);
    rd(3'd6, v);
    chk("R11 occupancy cleared", v, 0);

    wr(3'd6, 32'd5);
    rd(3'd5, v);
    chk("R8 over-release flag", 32'(v[4]), 1);

    wr(3'd3, 32'h0000_0000);
    fire(0);
    chk("R5 descriptor mode counts", 32'(irq_thresh), 1);
    rd(3'd7, v);
    chk("R5 descriptor mode count", v, 32'h0001_0010);

    for (int c = 0; c < 3000; c++) begin
      int r;
      upd_valid = ($urandom % 3) != 0;
      upd_last  = $urandom % 2;
      cfg_addr  = 3'($urandom % 8);
      cfg_we    = 0;
      r = $urandom % 16;
      if (r == 0) begin cfg_we = 1; cfg_addr = 3'd6; cfg_wdata = {8'd0, 8'($urandom % 4), 8'd0, 8'($urandom % 4)}; end
      else if (r == 1) begin cfg_we = 1; cfg_addr = 3'd5; cfg_wdata = $urandom; end
      else if (r == 2) begin cfg_we = 1; cfg_addr = 3'd3; cfg_wdata = {1'($urandom % 2), 27'd0, 4'($urandom % 6)}; end
      else if (r == 3) begin cfg_we = 1; cfg_addr = 3'd4; cfg_wdata = ($urandom % 5 != 0) ? 32'h0200_0001 : 32'h0; end
      else if (r == 4 && ($urandom % 8) == 0) begin cfg_we = 1; cfg_addr = 3'd1; cfg_wdata = 32'd32 + 32'($urandom % 200); end
      else if (r == 5 && ($urandom % 4) == 0) begin cfg_we = 1; cfg_addr = 3'd2; cfg_wdata = {16'd0, 8'($urandom), 8'(4 + $urandom % 24)}; end
      else if (r == 6 && ($urandom % 4) == 0) begin cfg_we = 1; cfg_addr = 3'd0; cfg_wdata = $urandom; end
      step();
    end
    cfg_we = 0; upd_valid = 0;
    step();
    summary();
  end
endmodule